// File: doc/BRIEF.md
# Speed-Sorted Shared-Bus Port Router

The router sits between four PHY ports and a repeater that sees only two shared buses. A fast bus carries nibble-wide receive data with its valid and error flags, plus nibble transmit data with a transmit error flag. A slow bus carries one serial receive bit and one serial transmit bit. Each port is placed on one bus from its negotiated speed and link state. No host is involved. A port changes bus only at a frame boundary: the first clock edge at which it is neither receiving (carrier low) nor being sent data.

The repeater picks the port it talks to by raising that port's receive or transmit enable. In separate mode each port has one enable pair and one carrier/collision pair per speed. In smart mode one common set per port serves both speeds: the fast-named pins act as the common enables and status. The slow transmit-enable pins become per-port security blocks that stop any transmit data from reaching that port. Receive, transmit and status paths are combinational from the inputs and the registered attachment state.

Top module: `bused_mii_router`

## Requirements
- R1: While rst_ni is low every port is detached: the bus receive outputs, all per-port transmit enables and data, and all carrier and collision outputs are 0.
- R2: A port with link_i high and no traffic is placed on the fast bus at the next clock edge if fast_i is 1, or on the slow bus if fast_i is 0.
- R3: While a port's carrier input is high, or the port is being sent data, its bus placement does not change. A pending speed or link change takes effect at the first edge after both have gone low.
- R4: The fast bus receive outputs carry {rx_er, rx_dv, rxd} of the lowest-numbered port that is on the fast bus and has its fast receive enable high. They are all 0 when no port qualifies.
- R5: The slow bus receive bit is the serial receive bit of the lowest-numbered port on the slow bus whose slow receive enable is high. In smart mode the fast receive enable is used instead. The bit is 0 when no port qualifies.
- R6: A port on the fast bus with its fast transmit enable high gets phy_tx_en_o=1 with bus_a_txd_i and bus_a_tx_er_i. Otherwise its fast transmit enable, data and error outputs are 0.
- R7: A port on the slow bus gets phy_txs_en_o=1 and the slow transmit bit while its slow transmit enable is high (the fast transmit enable in smart mode). Otherwise both outputs are 0. A port never has both transmit enables high.
- R8: In separate mode crs_fast_o/col_fast_o mirror the carrier/collision of ports on the fast bus and crs_slow_o/col_slow_o mirror those of ports on the slow bus. Every other bit is 0.
- R9: In smart mode crs_fast_o/col_fast_o mirror carrier/collision of every attached port whatever its speed, and crs_slow_o/col_slow_o stay 0.
- R10: In smart mode txen_slow_i[p]=1 forces both transmit paths of port p to 0. In separate mode the same pin is port p's ordinary slow transmit enable.
- R11: A port whose link_i is low is detached at its next idle edge. It then drives no bus, receives no transmit data and reports no status, whatever its enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| smart_mode_i | input | 1 | 1: smart (merged) control set, 0: separate per-speed sets |
| link_i | input | 4 | Per-port link up from negotiation |
| fast_i | input | 4 | Per-port negotiated speed, 1 = 100 Mbit, 0 = 10 Mbit |
| phy_crs_i | input | 4 | Per-port carrier sense from the PHY |
| phy_col_i | input | 4 | Per-port collision from the PHY |
| phy_rxd_i | input | 4x4 | Per-port receive nibble |
| phy_rx_dv_i | input | 4 | Per-port receive data valid |
| phy_rx_er_i | input | 4 | Per-port receive error |
| phy_rxs_i | input | 4 | Per-port serial receive bit |
| phy_txd_o | output | 4x4 | Per-port transmit nibble |
| phy_tx_en_o | output | 4 | Per-port nibble transmit enable |
| phy_tx_er_o | output | 4 | Per-port transmit error |
| phy_txs_o | output | 4 | Per-port serial transmit bit |
| phy_txs_en_o | output | 4 | Per-port serial transmit enable |
| rxen_fast_i | input | 4 | Fast receive enables (common receive enables in smart mode) |
| rxen_slow_i | input | 4 | Slow receive enables (unused in smart mode) |
| txen_fast_i | input | 4 | Fast transmit enables (common transmit enables in smart mode) |
| txen_slow_i | input | 4 | Slow transmit enables, security blocks in smart mode |
| bus_a_rxd_o | output | 4 | Fast bus receive nibble |
| bus_a_rx_dv_o | output | 1 | Fast bus receive valid |
| bus_a_rx_er_o | output | 1 | Fast bus receive error |
| bus_a_txd_i | input | 4 | Fast bus transmit nibble |
| bus_a_tx_er_i | input | 1 | Fast bus transmit error |
| bus_b_rxd_o | output | 1 | Slow bus serial receive bit |
| bus_b_txd_i | input | 1 | Slow bus serial transmit bit |
| crs_fast_o | output | 4 | Fast (smart: common) carrier per port |
| col_fast_o | output | 4 | Fast (smart: common) collision per port |
| crs_slow_o | output | 4 | Slow carrier per port |
| col_slow_o | output | 4 | Slow collision per port |

## Verification
The assertions take for granted that speed and link inputs are stable within a cycle. They also assume a port's carrier input reflects only its own receive activity, so a port under traffic is held in place and nothing else. The stimulus changes every input at the falling edge and sets up bus placements while all enables are low. It moves a port only while its carrier or transmit activity is being held or released deliberately. This way each placement change lands on a known edge and each routing check sees a settled placement.

// File: rtl/bmr_pkg.sv
package bmr_pkg;
  typedef enum logic [1:0] {
    ATT_NONE = 2'd0,
    ATT_SLOW = 2'd1,
    ATT_FAST = 2'd2
  } att_e;
endpackage

// File: rtl/bmr_attach.sv
module bmr_attach
  import bmr_pkg::*;
#(
  parameter int N_PORTS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_PORTS-1:0] link_i,
  input  logic [N_PORTS-1:0] fast_i,
  input  logic [N_PORTS-1:0] busy_i,
  output logic [N_PORTS-1:0] on_fast_o,
  output logic [N_PORTS-1:0] on_slow_o
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    att_e att_q, att_d;

    always_comb begin
      att_d = att_q;
      // placement may only move at a frame boundary
      if (!busy_i[p]) begin
        if (!link_i[p])     att_d = ATT_NONE;
        else if (fast_i[p]) att_d = ATT_FAST;
        else                att_d = ATT_SLOW;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) att_q <= ATT_NONE;
      else         att_q <= att_d;
    end

    assign on_fast_o[p] = (att_q == ATT_FAST);
    assign on_slow_o[p] = (att_q == ATT_SLOW);
  end
endmodule

// File: rtl/bmr_rx_arb.sv
module bmr_rx_arb #(
  parameter int N_PORTS = 4,
  parameter int W       = 6
) (
  input  logic [N_PORTS-1:0]        req_i,
  input  logic [N_PORTS-1:0][W-1:0] data_i,
  output logic [W-1:0]              data_o
);
  // lowest index has priority
  always_comb begin
    data_o = '0;
    for (int i = N_PORTS - 1; i >= 0; i--) begin
      if (req_i[i]) data_o = data_i[i];
    end
  end
endmodule

// File: rtl/bmr_tx_gate.sv
module bmr_tx_gate #(
  parameter int N_PORTS = 4,
  parameter int W       = 5
) (
  input  logic [N_PORTS-1:0]        en_i,
  input  logic [W-1:0]              bus_i,
  output logic [N_PORTS-1:0][W-1:0] data_o
);
  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assign data_o[p] = en_i[p] ? bus_i : '0;
  end
endmodule

// File: rtl/bused_mii_router.sv
module bused_mii_router #(
  parameter int N_PORTS = 4,
  parameter int NIB_W   = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          smart_mode_i,
  input  logic [N_PORTS-1:0]            link_i,
  input  logic [N_PORTS-1:0]            fast_i,
  input  logic [N_PORTS-1:0]            phy_crs_i,
  input  logic [N_PORTS-1:0]            phy_col_i,
  input  logic [N_PORTS-1:0][NIB_W-1:0] phy_rxd_i,
  input  logic [N_PORTS-1:0]            phy_rx_dv_i,
  input  logic [N_PORTS-1:0]            phy_rx_er_i,
  input  logic [N_PORTS-1:0]            phy_rxs_i,
  output logic [N_PORTS-1:0][NIB_W-1:0] phy_txd_o,
  output logic [N_PORTS-1:0]            phy_tx_en_o,
  output logic [N_PORTS-1:0]            phy_tx_er_o,
  output logic [N_PORTS-1:0]            phy_txs_o,
  output logic [N_PORTS-1:0]            phy_txs_en_o,
  input  logic [N_PORTS-1:0]            rxen_fast_i,
  input  logic [N_PORTS-1:0]            rxen_slow_i,
  input  logic [N_PORTS-1:0]            txen_fast_i,
  input  logic [N_PORTS-1:0]            txen_slow_i,
  output logic [NIB_W-1:0]              bus_a_rxd_o,
  output logic                          bus_a_rx_dv_o,
  output logic                          bus_a_rx_er_o,
  input  logic [NIB_W-1:0]              bus_a_txd_i,
  input  logic                          bus_a_tx_er_i,
  output logic                          bus_b_rxd_o,
  input  logic                          bus_b_txd_i,
  output logic [N_PORTS-1:0]            crs_fast_o,
  output logic [N_PORTS-1:0]            col_fast_o,
  output logic [N_PORTS-1:0]            crs_slow_o,
  output logic [N_PORTS-1:0]            col_slow_o
);
  localparam int RXA_W = NIB_W + 2;
  localparam int TXA_W = NIB_W + 1;

  logic [N_PORTS-1:0] on_fast, on_slow, busy;
  logic [N_PORTS-1:0] rx_req_a, rx_req_b, sec_blk, tx_ok_a, tx_ok_b;
  logic [N_PORTS-1:0][RXA_W-1:0] rx_word_a;
  logic [N_PORTS-1:0][TXA_W-1:0] tx_word_a;
  logic [N_PORTS-1:0][0:0]       rx_word_b, tx_word_b;
  logic [RXA_W-1:0] bus_a_word;
  logic [0:0]       bus_b_word;

  // effective enables; smart mode merges both speeds onto the fast-named pins
  assign sec_blk  = smart_mode_i ? txen_slow_i : '0;
  assign rx_req_a = on_fast & rxen_fast_i;
  assign rx_req_b = on_slow & (smart_mode_i ? rxen_fast_i : rxen_slow_i);
  assign tx_ok_a  = on_fast & txen_fast_i & ~sec_blk;
  assign tx_ok_b  = on_slow & (smart_mode_i ? txen_fast_i : txen_slow_i) & ~sec_blk;
  assign busy     = phy_crs_i | tx_ok_a | tx_ok_b;

  bmr_attach #(.N_PORTS(N_PORTS)) u_attach (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .link_i    (link_i),
    .fast_i    (fast_i),
    .busy_i    (busy),
    .on_fast_o (on_fast),
    .on_slow_o (on_slow)
  );

  for (genvar p = 0; p < N_PORTS; p++) begin : g_word
    assign rx_word_a[p]    = {phy_rx_er_i[p], phy_rx_dv_i[p], phy_rxd_i[p]};
    assign rx_word_b[p]    = phy_rxs_i[p];
    assign phy_txd_o[p]    = tx_word_a[p][NIB_W-1:0];
    assign phy_tx_er_o[p]  = tx_word_a[p][NIB_W];
    assign phy_txs_o[p]    = tx_word_b[p][0];
  end

  bmr_rx_arb #(.N_PORTS(N_PORTS), .W(RXA_W)) u_arb_a (
    .req_i  (rx_req_a),
    .data_i (rx_word_a),
    .data_o (bus_a_word)
  );

  bmr_rx_arb #(.N_PORTS(N_PORTS), .W(1)) u_arb_b (
    .req_i  (rx_req_b),
    .data_i (rx_word_b),
    .data_o (bus_b_word)
  );

  bmr_tx_gate #(.N_PORTS(N_PORTS), .W(TXA_W)) u_gate_a (
    .en_i   (tx_ok_a),
    .bus_i  ({bus_a_tx_er_i, bus_a_txd_i}),
    .data_o (tx_word_a)
  );

  bmr_tx_gate #(.N_PORTS(N_PORTS), .W(1)) u_gate_b (
    .en_i   (tx_ok_b),
    .bus_i  (bus_b_txd_i),
    .data_o (tx_word_b)
  );

  assign bus_a_rxd_o   = bus_a_word[NIB_W-1:0];
  assign bus_a_rx_dv_o = bus_a_word[NIB_W];
  assign bus_a_rx_er_o = bus_a_word[NIB_W+1];
  assign bus_b_rxd_o   = bus_b_word[0];
  assign phy_tx_en_o   = tx_ok_a;
  assign phy_txs_en_o  = tx_ok_b;

  always_comb begin
    if (smart_mode_i) begin
      crs_fast_o = phy_crs_i & (on_fast | on_slow);
      col_fast_o = phy_col_i & (on_fast | on_slow);
      crs_slow_o = '0;
      col_slow_o = '0;
    end else begin
      crs_fast_o = phy_crs_i & on_fast;
      col_fast_o = phy_col_i & on_fast;
      crs_slow_o = phy_crs_i & on_slow;
      col_slow_o = phy_col_i & on_slow;
    end
  end
endmodule

// File: rtl/bmr_checker.sv
module bmr_checker #(
  parameter int N_PORTS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               smart_mode_i,
  input logic [N_PORTS-1:0] link_i,
  input logic [N_PORTS-1:0] fast_i,
  input logic [N_PORTS-1:0] busy_i,
  input logic [N_PORTS-1:0] on_fast_i,
  input logic [N_PORTS-1:0] on_slow_i,
  input logic [N_PORTS-1:0] txen_slow_i,
  input logic [N_PORTS-1:0] phy_tx_en_i,
  input logic [N_PORTS-1:0] phy_txs_en_i,
  input logic [N_PORTS-1:0] crs_slow_i,
  input logic [N_PORTS-1:0] col_slow_i
);
  assert_one_tx_path_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(phy_tx_en_i & phy_txs_en_i) == 0);

  assert_smart_slow_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smart_mode_i |-> (crs_slow_i == '0 && col_slow_i == '0));

  assert_security_block_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smart_mode_i |-> ((txen_slow_i & (phy_tx_en_i | phy_txs_en_i)) == '0));

  for (genvar p = 0; p < N_PORTS; p++) begin : g_port
    assert_hold_when_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      busy_i[p] |=> ($stable(on_fast_i[p]) && $stable(on_slow_i[p])));

    assert_attach_fast_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (link_i[p] && fast_i[p] && !busy_i[p]) |=> (on_fast_i[p] && !on_slow_i[p]));

    assert_attach_slow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (link_i[p] && !fast_i[p] && !busy_i[p]) |=> (on_slow_i[p] && !on_fast_i[p]));

    assert_detach_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!link_i[p] && !busy_i[p]) |=> (!on_fast_i[p] && !on_slow_i[p]));
  end
endmodule

bind bused_mii_router bmr_checker #(.N_PORTS(N_PORTS)) u_bmr_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .smart_mode_i (smart_mode_i),
  .link_i       (link_i),
  .fast_i       (fast_i),
  .busy_i       (busy),
  .on_fast_i    (on_fast),
  .on_slow_i    (on_slow),
  .txen_slow_i  (txen_slow_i),
  .phy_tx_en_i  (phy_tx_en_o),
  .phy_txs_en_i (phy_txs_en_o),
  .crs_slow_i   (crs_slow_o),
  .col_slow_i   (col_slow_o)
);

// File: tb/bused_mii_router_bench.sv
module bused_mii_router_bench;
  localparam int NP = 4;
  localparam int NW = 4;

  typedef struct packed {
    logic       smart;
    logic [3:0] rf, rs, tf, ts;
    logic [5:0] ea;
    logic       eb;
    logic [3:0] etx, etxs;
  } vec_t;

  // placement during the walk: ports 0,2 fast, ports 1,3 slow
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 6'h00, 1'b0, 4'b0000, 4'b0000},
    '{1'b0, 4'b0101, 4'b0000, 4'b0000, 4'b0000, 6'h11, 1'b0, 4'b0000, 4'b0000},
    '{1'b0, 4'b0100, 4'b1000, 4'b0000, 4'b0000, 6'h33, 1'b1, 4'b0000, 4'b0000},
    '{1'b0, 4'b0010, 4'b1001, 4'b0000, 4'b0000, 6'h00, 1'b1, 4'b0000, 4'b0000},
    '{1'b0, 4'b0000, 4'b1010, 4'b0000, 4'b0000, 6'h00, 1'b0, 4'b0000, 4'b0000},
    '{1'b0, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 6'h00, 1'b0, 4'b0101, 4'b0000},
    '{1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 6'h00, 1'b0, 4'b0000, 4'b1010},
    '{1'b1, 4'b1000, 4'b0010, 4'b0000, 4'b0000, 6'h00, 1'b1, 4'b0000, 4'b0000},
    '{1'b1, 4'b0101, 4'b0000, 4'b0000, 4'b0000, 6'h11, 1'b0, 4'b0000, 4'b0000},
    '{1'b1, 4'b0000, 4'b0000, 4'b1111, 4'b0000, 6'h00, 1'b0, 4'b0101, 4'b1010},
    '{1'b1, 4'b0000, 4'b0000, 4'b1111, 4'b0011, 6'h00, 1'b0, 4'b0100, 4'b1000},
    '{1'b0, 4'b0000, 4'b0000, 4'b0000, 4'b0011, 6'h00, 1'b0, 4'b0000, 4'b0010}
  };

  logic clk = 1'b0;
  logic rst_ni;
  logic smart_mode;
  logic [NP-1:0] link, fast, crs, col, rx_dv, rx_er, rxs;
  logic [NP-1:0][NW-1:0] rxd;
  logic [NP-1:0][NW-1:0] txd;
  logic [NP-1:0] tx_en, tx_er, txs, txs_en;
  logic [NP-1:0] rxen_fast, rxen_slow, txen_fast, txen_slow;
  logic [NW-1:0] a_rxd, a_txd;
  logic a_dv, a_er, a_tx_er, b_rxd, b_txd;
  logic [NP-1:0] crs_f, col_f, crs_s, col_s;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bused_mii_router #(.N_PORTS(NP), .NIB_W(NW)) u_bused_mii_router (
    .clk_i(clk), .rst_ni(rst_ni), .smart_mode_i(smart_mode),
    .link_i(link), .fast_i(fast), .phy_crs_i(crs), .phy_col_i(col),
    .phy_rxd_i(rxd), .phy_rx_dv_i(rx_dv), .phy_rx_er_i(rx_er), .phy_rxs_i(rxs),
    .phy_txd_o(txd), .phy_tx_en_o(tx_en), .phy_tx_er_o(tx_er),
    .phy_txs_o(txs), .phy_txs_en_o(txs_en),
    .rxen_fast_i(rxen_fast), .rxen_slow_i(rxen_slow),
    .txen_fast_i(txen_fast), .txen_slow_i(txen_slow),
    .bus_a_rxd_o(a_rxd), .bus_a_rx_dv_o(a_dv), .bus_a_rx_er_o(a_er),
    .bus_a_txd_i(a_txd), .bus_a_tx_er_i(a_tx_er),
    .bus_b_rxd_o(b_rxd), .bus_b_txd_i(b_txd),
    .crs_fast_o(crs_f), .col_fast_o(col_f), .crs_slow_o(crs_s), .col_slow_o(col_s)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_en(input logic [3:0] rf, input logic [3:0] rs,
                        input logic [3:0] tf, input logic [3:0] ts);
    rxen_fast = rf; rxen_slow = rs; txen_fast = tf; txen_slow = ts;
  endtask

  function automatic logic [5:0] bus_a_word();
    return {a_er, a_dv, a_rxd};
  endfunction

  initial begin
    #(20000 * 4);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_txd;
    rst_ni = 1'b0;
    smart_mode = 1'b0;
    link = 4'b1111; fast = 4'b0101;
    crs = 4'b1111; col = 4'b1111;
    rxd = {4'h4, 4'h3, 4'h2, 4'h1};
    rx_dv = 4'b1111; rx_er = 4'b0100; rxs = 4'b1101;
    a_txd = 4'hC; a_tx_er = 1'b1; b_txd = 1'b1;
    set_en(4'b1111, 4'b1111, 4'b1111, 4'b1111);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    // R1: detached during reset even with everything enabled
    check("R1 bus A word", 32'(bus_a_word()), 32'h0);
    check("R1 bus B bit", 32'(b_rxd), 32'h0);
    check("R1 tx enables", 32'({tx_en, txs_en}), 32'h0);
    check("R1 status", 32'({crs_f, col_f, crs_s, col_s}), 32'h0);

    @(negedge clk);
    set_en(4'b0000, 4'b0000, 4'b0000, 4'b0000);
    crs = 4'b0000; col = 4'b0000;
    rst_ni = 1'b1;
    @(posedge clk); @(negedge clk); #1;

    // R2: placement by speed, seen through the fast/slow status split
    crs = 4'b1111;
    #1;
    check("R2 fast placement", 32'(crs_f), 32'h5);
    check("R2 slow placement", 32'(crs_s), 32'hA);
    // R8: separate-mode status
    col = 4'b0110;
    #1;
    check("R8 col fast", 32'(col_f), 32'h4);
    check("R8 col slow", 32'(col_s), 32'h2);
    // R9: smart-mode status
    smart_mode = 1'b1;
    #1;
    check("R9 crs common", 32'(crs_f), 32'hF);
    check("R9 col common", 32'(col_f), 32'h6);
    check("R9 slow quiet", 32'({crs_s, col_s}), 32'h0);
    @(negedge clk);
    smart_mode = 1'b0; crs = 4'b0000; col = 4'b0000;

    // vector walk: R4 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      smart_mode = VECS[v].smart;
      set_en(VECS[v].rf, VECS[v].rs, VECS[v].tf, VECS[v].ts);
      #1;
      for (int p = 0; p < NP; p++) exp_txd[p*4 +: 4] = VECS[v].etx[p] ? 4'hC : 4'h0;
      check($sformatf("R4 vec%0d bus A", v), 32'(bus_a_word()), 32'(VECS[v].ea));
      check($sformatf("R5 vec%0d bus B", v), 32'(b_rxd), 32'(VECS[v].eb));
      check($sformatf("R6 R10 vec%0d tx_en", v), 32'(tx_en), 32'(VECS[v].etx));
      check($sformatf("R6 vec%0d txd", v), 32'(txd), 32'(exp_txd));
      check($sformatf("R6 vec%0d tx_er", v), 32'(tx_er), 32'(VECS[v].etx));
      check($sformatf("R7 R10 vec%0d txs_en", v), 32'(txs_en), 32'(VECS[v].etxs));
      check($sformatf("R7 vec%0d txs", v), 32'(txs), 32'(VECS[v].etxs));
    end

    // R3: carrier on port 0 holds it on the fast bus
    @(negedge clk);
    smart_mode = 1'b0;
    set_en(4'b0001, 4'b0001, 4'b0000, 4'b0000);
    crs = 4'b0001; fast = 4'b0100;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R3 hold under carrier", 32'(bus_a_word()), 32'h11);
    crs = 4'b0000;
    @(posedge clk); @(negedge clk); #1;
    check("R3 moved after carrier drop A", 32'(bus_a_word()), 32'h0);
    check("R3 moved after carrier drop B", 32'(b_rxd), 32'h1);

    // R3: transmit on port 2 holds it on the fast bus
    set_en(4'b0000, 4'b0000, 4'b0100, 4'b0000);
    fast = 4'b0000;
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    check("R3 hold under transmit", 32'(tx_en), 32'h4);
    set_en(4'b0000, 4'b0000, 4'b0000, 4'b0000);
    @(posedge clk); @(negedge clk);
    set_en(4'b0000, 4'b0000, 4'b0000, 4'b0100);
    #1;
    check("R2 port 2 now slow", 32'(txs_en), 32'h4);
    check("R2 port 2 off fast", 32'(tx_en), 32'h0);

    // R11: link loss on port 3
    @(negedge clk);
    set_en(4'b0000, 4'b0000, 4'b0000, 4'b0000);
    link = 4'b0111;
    @(posedge clk); @(negedge clk);
    set_en(4'b1000, 4'b1000, 4'b1000, 4'b1000);
    crs = 4'b1000; col = 4'b1000;
    #1;
    check("R11 no bus B drive", 32'(b_rxd), 32'h0);
    check("R11 no tx", 32'({tx_en, txs_en}), 32'h0);
    check("R11 no status", 32'({crs_f, col_f, crs_s, col_s}), 32'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule